// File: doc/BRIEF.md
# Bus Strobe Deskew Timer

This timer sits between a processor and an asynchronous I/O bus. When a transfer starts, it turns on the address and data drivers at once. It then holds back the bus control strobe for a settling interval so that the strobe always lags its qualifying signals, whatever the skew along the bus.

The interval is chosen per transfer from a target-type flag. A nearby memory gets a short wait and a distant peripheral gets a long one, so memory transfers do not pay the worst-case delay. Both waits are counted in cycles of the system clock and are parameters. At 40 MHz, a 25 ns memory settle rounds to 1 cycle and a 150 ns peripheral settle is 6 cycles.

A `done_o` pulse marks the cycle in which the strobe comes on. The strobe is then held until the requester signals the end of the transfer. A start pulse that arrives while a transfer is in progress is ignored, and `busy_o` shows when that is the case.

Top module: `dsk_strobe_unit`

## Requirements
- R1: After a synchronous reset, `drive_o`, `strobe_o`, `done_o` and `busy_o` are all low.
- R2: A `start_i` pulse while idle raises `drive_o` and `busy_o` in the next cycle, with `strobe_o` still low.
- R3: With `periph_i` = 0 at the start, `strobe_o` rises MEM_CYC cycles (default 1) after `drive_o` rises.
- R4: With `periph_i` = 1 at the start, `strobe_o` rises PER_CYC cycles (default 6) after `drive_o` rises.
- R5: `done_o` is high for exactly one cycle, namely the first cycle in which `strobe_o` is high.
- R6: `strobe_o` stays high until `end_i` is sampled high. In the following cycle `strobe_o`, `drive_o` and `busy_o` are all low.
- R7: A `start_i` pulse while `busy_o` is high is ignored: it neither restarts the settle count nor starts a second transfer.
- R8: `end_i` sampled during the settle interval, before the strobe rises, has no effect.
- R9: When `start_i` and `end_i` are high together while the strobe is on, the end takes effect and the start is dropped. The unit is idle afterwards.
- R10: `periph_i` is sampled only in the cycle in which a start is accepted. Later changes do not alter the interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin a transfer |
| periph_i | input | 1 | Target type: 1 = distant peripheral, 0 = nearby memory |
| end_i | input | 1 | Requester ends the strobe phase |
| drive_o | output | 1 | Enables the address and data drivers |
| strobe_o | output | 1 | Delayed bus control strobe |
| done_o | output | 1 | One-cycle pulse when the settle interval has elapsed |
| busy_o | output | 1 | A transfer is in progress and new starts are ignored |

## Verification
Two pairs of events can fall in the same cycle. The first is a new start arriving during a settle interval, possibly with the opposite target type. The second is a start arriving together with the end request while the strobe is on.

The bench drives the first pair by pulsing `start_i` with a flipped `periph_i` partway through a peripheral settle. It then checks that the measured lag is still the peripheral count. It drives the second pair by raising `start_i` and `end_i` on the same edge. It then checks that the unit drops to idle and stays idle on the following cycles, with no drive or strobe.

// File: rtl/dsk_pkg.sv
package dsk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_STROBE = 2'd2
  } dsk_state_e;
endpackage

// File: rtl/dsk_delay_sel.sv
module dsk_delay_sel #(
  parameter int MEM_CYC = 1,
  parameter int PER_CYC = 6,
  parameter int CW      = 3
) (
  input  logic          periph_i,
  output logic [CW-1:0] load_o
);
  // The counter is loaded with (cycles - 1) so that strobe rises after exactly N cycles.
  localparam logic [CW-1:0] MEM_LOAD = CW'(MEM_CYC - 1);
  localparam logic [CW-1:0] PER_LOAD = CW'(PER_CYC - 1);

  always_comb load_o = periph_i ? PER_LOAD : MEM_LOAD;
endmodule

// File: rtl/dsk_counter.sv
module dsk_counter #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/dsk_fsm.sv
module dsk_fsm
  import dsk_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic end_i,
  input  logic zero_i,
  output logic load_o,
  output logic drive_o,
  output logic strobe_o,
  output logic done_o,
  output logic busy_o
);
  dsk_state_e state_q;

  // A start is accepted only while idle.
  assign load_o = (state_q == ST_IDLE) && start_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      drive_o  <= 1'b0;
      strobe_o <= 1'b0;
      done_o   <= 1'b0;
      busy_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_SETTLE;
          drive_o <= 1'b1;
          busy_o  <= 1'b1;
        end
        ST_SETTLE: if (zero_i) begin
          state_q  <= ST_STROBE;
          strobe_o <= 1'b1;
          done_o   <= 1'b1;
        end
        ST_STROBE: if (end_i) begin
          state_q  <= ST_IDLE;
          drive_o  <= 1'b0;
          strobe_o <= 1'b0;
          busy_o   <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dsk_strobe_unit.sv
module dsk_strobe_unit #(
  parameter int MEM_CYC = 1,
  parameter int PER_CYC = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic periph_i,
  input  logic end_i,
  output logic drive_o,
  output logic strobe_o,
  output logic done_o,
  output logic busy_o
);
  localparam int MAX_CYC = (MEM_CYC > PER_CYC) ? MEM_CYC : PER_CYC;
  localparam int CW      = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  logic [CW-1:0] load_val;
  logic          load;
  logic          zero;

  dsk_delay_sel #(.MEM_CYC(MEM_CYC), .PER_CYC(PER_CYC), .CW(CW)) u_sel (
    .periph_i (periph_i),
    .load_o   (load_val)
  );

  dsk_counter #(.CW(CW)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load),
    .load_val_i (load_val),
    .zero_o     (zero)
  );

  dsk_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .end_i    (end_i),
    .zero_i   (zero),
    .load_o   (load),
    .drive_o  (drive_o),
    .strobe_o (strobe_o),
    .done_o   (done_o),
    .busy_o   (busy_o)
  );
endmodule

// File: rtl/dsk_strobe_unit_chk.sv
module dsk_strobe_unit_chk #(
  parameter int MEM_CYC = 1,
  parameter int PER_CYC = 6
) (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic periph_i,
  input logic end_i,
  input logic drive_o,
  input logic strobe_o,
  input logic done_o,
  input logic busy_o
);
  logic        tgt_q;
  int unsigned lag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q <= 1'b0;
      lag_q <= 0;
    end else begin
      if (!busy_o && start_i) tgt_q <= periph_i;
      lag_q <= (drive_o && !strobe_o) ? lag_q + 1 : 0;
    end
  end

  a_r2_strobe_needs_drive: assert property (@(posedge clk) disable iff (rst)
    strobe_o |-> drive_o && busy_o);

  a_r2_start_accepted: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i) |=> drive_o && busy_o && !strobe_o);

  a_r3_r4_lag_by_target: assert property (@(posedge clk) disable iff (rst)
    $rose(strobe_o) |-> (lag_q == (tgt_q ? PER_CYC : MEM_CYC)));

  a_r5_done_with_rise: assert property (@(posedge clk) disable iff (rst)
    done_o |-> strobe_o && $rose(strobe_o));

  a_r6_end_releases: assert property (@(posedge clk) disable iff (rst)
    (strobe_o && end_i) |=> !strobe_o && !drive_o && !busy_o);

  a_r7_settle_holds: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !strobe_o) |=> busy_o && drive_o);
endmodule

bind dsk_strobe_unit dsk_strobe_unit_chk #(.MEM_CYC(MEM_CYC), .PER_CYC(PER_CYC)) u_chk (.*);

// File: tb/tb_dsk_strobe_unit.sv
module tb_dsk_strobe_unit;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_CYC = 1;
  localparam int PER_CYC = 6;
  localparam int NVEC = 6;
  // {periph, hold cycles of strobe before end}
  localparam logic [4:0] VEC [NVEC] = '{5'h00, 5'h13, 5'h02, 5'h10, 5'h05, 5'h11};

  logic clk = 0, rst = 1, start_i = 0, periph_i = 0, end_i = 0;
  logic drive_o, strobe_o, done_o, busy_o;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsk_strobe_unit #(.MEM_CYC(MEM_CYC), .PER_CYC(PER_CYC)) dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Issue a start, count cycles from drive to strobe; returns lag.
  task automatic begin_xfer(input bit per, input string req, output int lag);
    @(negedge clk); start_i = 1; periph_i = per;
    @(negedge clk); start_i = 0;
    chk(drive_o && busy_o && !strobe_o, "R2", {drive_o, busy_o, strobe_o}, 3'b110);
    lag = 1;
    while (!strobe_o && lag < 50) begin
      @(negedge clk);
      if (!strobe_o) lag++;
    end
    chk(lag == (per ? PER_CYC : MEM_CYC), req, lag, per ? PER_CYC : MEM_CYC);
    chk(done_o, "R5", done_o, 1);
  endtask

  task automatic finish_xfer(input int hold);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(strobe_o && !done_o, "R6/R5 hold", {strobe_o, done_o}, 2'b10);
    end
    end_i = 1;
    @(negedge clk); end_i = 0;
    chk(!strobe_o && !drive_o && !busy_o, "R6", {strobe_o, drive_o, busy_o}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lag;
    repeat (3) @(negedge clk);
    chk({drive_o, strobe_o, done_o, busy_o} == 0, "R1", {drive_o, strobe_o, done_o, busy_o}, 0);
    rst = 0;

    // Table walk: R3 (memory) and R4 (peripheral) lags, R6 hold.
    for (int v = 0; v < NVEC; v++) begin
      begin_xfer(VEC[v][4], VEC[v][4] ? "R4" : "R3", lag);
      finish_xfer(int'(VEC[v][3:0]));
    end

    // R7 + R10: restart attempt with flipped target during peripheral settle.
    @(negedge clk); start_i = 1; periph_i = 1;
    @(negedge clk); start_i = 1; periph_i = 0;
    @(negedge clk); start_i = 0;
    lag = 2;
    while (!strobe_o && lag < 50) begin
      @(negedge clk);
      if (!strobe_o) lag++;
    end
    chk(lag == PER_CYC, "R7/R10", lag, PER_CYC);
    finish_xfer(0);
    @(negedge clk);
    chk(!busy_o && !drive_o, "R7 no second transfer", busy_o, 0);

    // R8: end during settle ignored.
    @(negedge clk); start_i = 1; periph_i = 1;
    @(negedge clk); start_i = 0; end_i = 1;
    @(negedge clk); end_i = 0;
    chk(busy_o && drive_o && !strobe_o, "R8 settle continues", busy_o, 1);
    repeat (PER_CYC) @(negedge clk);
    chk(strobe_o, "R8 strobe rises", strobe_o, 1);
    @(negedge clk);
    chk(strobe_o, "R8 strobe held", strobe_o, 1);

    // R9: start and end together while strobe on.
    start_i = 1; end_i = 1;
    @(negedge clk); start_i = 0; end_i = 0;
    chk(!busy_o && !drive_o && !strobe_o, "R9 idle", {busy_o, drive_o, strobe_o}, 0);
    @(negedge clk);
    chk(!busy_o && !drive_o, "R9 no new transfer", {busy_o, drive_o}, 0);

    // R1: reset mid-transfer.
    @(negedge clk); start_i = 1; periph_i = 1;
    @(negedge clk); start_i = 0; rst = 1;
    @(negedge clk); rst = 0;
    chk({drive_o, strobe_o, done_o, busy_o} == 0, "R1 mid", {drive_o, strobe_o, done_o, busy_o}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule